// File: doc/BRIEF.md
# Size-Configurable ROM Bank Select Decoder

This block produces the chip enables for a cartridge data space made of up to four ROM slots (or four pairs of ROMs). Every fitted device has the same size. A static size setting picks which two address bits feed a 2-to-4 decoder. During an access, the decoder pulls exactly one active-low slot enable low. The same setting masks the address handed on to the devices, so that only the bits inside one device pass through.

At the largest device size, the direct address is too narrow to reach the slot bits. The select pair then comes from a small upper-address register that the host loads separately. The block also folds two active-low output-enable requests into a single read strobe for the ROMs.

The same board can take a 4 Mbit part, but only when it is the single ROM fitted and it sits in the last used slot. That is an assembly rule and needs no logic here.

Top module: `rom_bank_sel`

## Requirements
- R1: With size_i = 2'b01 (8 Mbit) and acc_i high, the selected slot index is {addr_i[20], addr_i[19]}, and slot k is enabled by driving slot_en_no[k] low.
- R2: With size_i = 2'b10 (16 Mbit) and acc_i high, the selected slot index is {addr_i[21], addr_i[20]}.
- R3: With size_i = 2'b11 (32 Mbit) and acc_i high, the selected slot index is the upper-address register {ext[1], ext[0]}. The register loads ext_d_i on a rising clk_i edge while ext_we_i is high, and it resets to 2'b00.
- R4: While acc_i is high and size_i is not 2'b00, exactly one bit of slot_en_no is low.
- R5: While acc_i is low, slot_en_no is 4'hF.
- R6: size_i = 2'b00 is reserved. It forces slot_en_no to 4'hF and rom_addr_o to zero.
- R7: rd_n_o is low when oe_a_ni or oe_b_ni is low, and high only when both are high.
- R8: Address bits above the active select pair have no effect on slot selection. At 32 Mbit, no direct address bit has any effect on slot selection.
- R9: rom_addr_o passes the address bits below the device boundary unchanged and clears all other bits. The boundary is bit 19 at 8 Mbit, bit 20 at 16 Mbit and bit 21 at 32 Mbit.
- R10: The upper-address register keeps its value while ext_we_i is low, whatever ext_d_i does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the upper-address register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| acc_i | input | 1 | Access strobe; enables are inactive without it |
| addr_i | input | 22 | Direct access address |
| size_i | input | 2 | Device size: 01 = 8M, 10 = 16M, 11 = 32M, 00 = reserved |
| ext_we_i | input | 1 | Load strobe for the upper-address register |
| ext_d_i | input | 2 | Upper-address register data |
| oe_a_ni | input | 1 | Output-enable request A, active low |
| oe_b_ni | input | 1 | Output-enable request B, active low |
| slot_en_no | output | 4 | Slot enables, active low, one-hot-low during an access |
| rd_n_o | output | 1 | Merged read strobe, active low |
| rom_addr_o | output | 22 | Masked address for the devices |

## Verification
The bench walks all four slots at each valid size. A decoder wired to the wrong bit pair would enable the neighbouring slot, or the same slot for two indices. It toggles the bit just above the select pair, which catches a decoder that lets an upper bit alias into the slot. At 32 Mbit it loads the upper register and then changes the data with the load strobe low. A register that ignored its strobe would move the enable, and one that missed its reset would not start on slot 0. The reserved size, the idle strobe and all four output-enable combinations are also covered, so a lost gating term shows up as a stray low enable or a wrong read strobe.

// File: rtl/rom_bank_pkg.sv
package rom_bank_pkg;
  typedef enum logic [1:0] {
    SZ_RSV = 2'b00,
    SZ_8M  = 2'b01,
    SZ_16M = 2'b10,
    SZ_32M = 2'b11
  } size_e;
endpackage

// File: rtl/rbs_ext_latch.sv
module rbs_ext_latch #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/rbs_sel_mux.sv
module rbs_sel_mux
  import rom_bank_pkg::*;
#(
  parameter int ADDR_W   = 22,
  parameter int BASE_BIT = 19,
  parameter int SEL_W    = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SEL_W-1:0]  ext_i,
  input  logic [1:0]        size_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic              sel_ok_o,
  output logic [ADDR_W-1:0] rom_addr_o
);
  // device span grows one bit per size step
  localparam logic [ADDR_W-1:0] MASK_8M  = {ADDR_W{1'b1}} >> (ADDR_W - BASE_BIT);
  localparam logic [ADDR_W-1:0] MASK_16M = {ADDR_W{1'b1}} >> (ADDR_W - BASE_BIT - 1);
  localparam logic [ADDR_W-1:0] MASK_32M = {ADDR_W{1'b1}} >> (ADDR_W - BASE_BIT - 2);

  always_comb begin
    sel_o      = '0;
    sel_ok_o   = 1'b1;
    rom_addr_o = '0;
    unique case (size_e'(size_i))
      SZ_8M: begin
        sel_o      = addr_i[BASE_BIT +: SEL_W];
        rom_addr_o = addr_i & MASK_8M;
      end
      SZ_16M: begin
        sel_o      = addr_i[BASE_BIT+1 +: SEL_W];
        rom_addr_o = addr_i & MASK_16M;
      end
      SZ_32M: begin
        sel_o      = ext_i;
        rom_addr_o = addr_i & MASK_32M;
      end
      default: sel_ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rbs_dec.sv
module rbs_dec #(
  parameter int SEL_W = 2,
  localparam int N_SLOT = 1 << SEL_W
) (
  input  logic              en_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [N_SLOT-1:0] y_no
);
  for (genvar k = 0; k < N_SLOT; k++) begin : g_slot
    assign y_no[k] = !(en_i && (sel_i == SEL_W'(k)));
  end
endmodule

// File: rtl/rom_bank_sel.sv
module rom_bank_sel #(
  parameter int ADDR_W   = 22,
  parameter int BASE_BIT = 19,
  parameter int SEL_W    = 2,
  localparam int N_SLOT  = 1 << SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              ext_we_i,
  input  logic [SEL_W-1:0]  ext_d_i,
  input  logic              oe_a_ni,
  input  logic              oe_b_ni,
  output logic [N_SLOT-1:0] slot_en_no,
  output logic              rd_n_o,
  output logic [ADDR_W-1:0] rom_addr_o
);
  logic [SEL_W-1:0] ext_q;
  logic [SEL_W-1:0] sel;
  logic             sel_ok;

  rbs_ext_latch #(.W(SEL_W)) u_ext (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (ext_we_i),
    .d_i   (ext_d_i),
    .q_o   (ext_q)
  );

  rbs_sel_mux #(.ADDR_W(ADDR_W), .BASE_BIT(BASE_BIT), .SEL_W(SEL_W)) u_mux (
    .addr_i    (addr_i),
    .ext_i     (ext_q),
    .size_i    (size_i),
    .sel_o     (sel),
    .sel_ok_o  (sel_ok),
    .rom_addr_o(rom_addr_o)
  );

  rbs_dec #(.SEL_W(SEL_W)) u_dec (
    .en_i (acc_i && sel_ok),
    .sel_i(sel),
    .y_no (slot_en_no)
  );

  // active-low AND: either request pulls the strobe low
  assign rd_n_o = oe_a_ni & oe_b_ni;
endmodule

// File: rtl/rom_bank_sel_chk.sv
module rom_bank_sel_chk #(
  parameter int ADDR_W   = 22,
  parameter int BASE_BIT = 19
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acc_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [1:0]        size_i,
  input logic              ext_we_i,
  input logic              oe_a_ni,
  input logic              oe_b_ni,
  input logic [3:0]        slot_en_no,
  input logic              rd_n_o
);
  p_sel8_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && size_i == 2'b01) |-> !slot_en_no[addr_i[BASE_BIT +: 2]]);

  p_sel16_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && size_i == 2'b10) |-> !slot_en_no[addr_i[BASE_BIT+1 +: 2]]);

  p_one_hot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && size_i != 2'b00) |-> ($countones(~slot_en_no) == 1));

  p_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_i |-> (slot_en_no == 4'hF));

  p_rsv_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i == 2'b00) |-> (slot_en_no == 4'hF));

  p_rd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_a_ni || !oe_b_ni) |-> !rd_n_o);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(ext_we_i) && size_i == 2'b11 && $past(size_i) == 2'b11 && acc_i && $past(acc_i))
      |-> $stable(slot_en_no));
endmodule

bind rom_bank_sel rom_bank_sel_chk #(.ADDR_W(ADDR_W), .BASE_BIT(BASE_BIT)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .acc_i     (acc_i),
  .addr_i    (addr_i),
  .size_i    (size_i),
  .ext_we_i  (ext_we_i),
  .oe_a_ni   (oe_a_ni),
  .oe_b_ni   (oe_b_ni),
  .slot_en_no(slot_en_no),
  .rd_n_o    (rd_n_o)
);

// File: tb/rom_bank_sel_tb_top.sv
module rom_bank_sel_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        acc_i = 1'b0;
  logic [21:0] addr_i = '0;
  logic [1:0]  size_i = 2'b01;
  logic        ext_we_i = 1'b0;
  logic [1:0]  ext_d_i = '0;
  logic        oe_a_ni = 1'b1;
  logic        oe_b_ni = 1'b1;
  logic [3:0]  slot_en_no;
  logic        rd_n_o;
  logic [21:0] rom_addr_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5ns clk_i = ~clk_i;

  rom_bank_sel dut_i (.*);

  function automatic logic [3:0] en_of(int k);
    return ~(4'b0001 << k);
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic drive(logic a, logic [1:0] sz, logic [21:0] ad);
    @(negedge clk_i);
    acc_i = a; size_i = sz; addr_i = ad;
    #1;
  endtask

  task automatic load_ext(logic [1:0] d);
    @(negedge clk_i);
    ext_d_i = d; ext_we_i = 1'b1;
    @(negedge clk_i);
    ext_we_i = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    drive(1'b0, 2'b11, '0);
    chk("R5 idle after reset", 32'(slot_en_no), 32'hF);
    drive(1'b1, 2'b11, '0);
    chk("R3 register reset value", 32'(slot_en_no), 32'(en_of(0)));
  endtask

  task automatic t_size8;
    for (int k = 0; k < 4; k++) begin
      drive(1'b1, 2'b01, (22'(k) << 19) | 22'h2_5A5A);
      chk("R1 8M slot", 32'(slot_en_no), 32'(en_of(k)));
      chk("R4 single enable", 32'($countones(~slot_en_no)), 1);
      chk("R9 8M address mask", 32'(rom_addr_o), 32'h2_5A5A);
    end
  endtask

  task automatic t_size16;
    for (int k = 0; k < 4; k++) begin
      drive(1'b1, 2'b10, (22'(k) << 20) | 22'h8_0000 | 22'h0_1234);
      chk("R2 16M slot", 32'(slot_en_no), 32'(en_of(k)));
      chk("R9 16M address mask", 32'(rom_addr_o), 32'h8_1234);
    end
  endtask

  task automatic t_upper;
    drive(1'b1, 2'b01, 22'h10_0000 | 22'h20_0000);
    chk("R8 A21 ignored at 8M", 32'(slot_en_no), 32'(en_of(2)));
    chk("R9 upper bits cleared", 32'(rom_addr_o), 0);
    drive(1'b1, 2'b01, 22'h10_0000);
    chk("R8 A21 ignored at 8M", 32'(slot_en_no), 32'(en_of(2)));
  endtask

  task automatic t_size32;
    load_ext(2'b10);
    drive(1'b1, 2'b11, 22'h3F_FFFF);
    chk("R3 32M slot from register", 32'(slot_en_no), 32'(en_of(2)));
    chk("R9 32M address mask", 32'(rom_addr_o), 32'h1F_FFFF);
    drive(1'b1, 2'b11, 22'h00_0000);
    chk("R8 direct address ignored at 32M", 32'(slot_en_no), 32'(en_of(2)));
    @(negedge clk_i);
    ext_d_i = 2'b01;
    @(negedge clk_i);
    #1;
    chk("R10 register holds", 32'(slot_en_no), 32'(en_of(2)));
    load_ext(2'b11);
    chk("R3 reload", 32'(slot_en_no), 32'(en_of(3)));
  endtask

  task automatic t_reserved;
    drive(1'b1, 2'b00, 22'h3F_FFFF);
    chk("R6 reserved enables", 32'(slot_en_no), 32'hF);
    chk("R6 reserved address", 32'(rom_addr_o), 0);
  endtask

  task automatic t_idle;
    drive(1'b0, 2'b01, 22'h18_0000);
    chk("R5 no strobe 8M", 32'(slot_en_no), 32'hF);
    drive(1'b0, 2'b10, 22'h30_0000);
    chk("R5 no strobe 16M", 32'(slot_en_no), 32'hF);
  endtask

  task automatic t_oe;
    for (int v = 0; v < 4; v++) begin
      @(negedge clk_i);
      oe_a_ni = v[0]; oe_b_ni = v[1];
      #1;
      chk("R7 read strobe", 32'(rd_n_o), (v == 3) ? 1 : 0);
    end
  endtask

  initial begin
    #23ns rst_ni = 1'b1;
    t_reset();
    t_size8();
    t_size16();
    t_upper();
    t_size32();
    t_reserved();
    t_idle();
    t_oe();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule